// File: doc/BRIEF.md
# Banked Dual-Address Byte Memory

This block is a byte-wide storage of 2048 entries split into sixteen independent sub-banks, grouped as four banks of four sub-banks each. It has one read address and one write address, so a read and a write can be presented together in the same clock cycle. When the two requests land in different sub-banks, both are carried out in parallel. When they land in the same sub-bank, the read wins and the write is discarded without touching storage.

The upper four address bits pick the sub-bank. The upper two of those four bits name the bank and the lower two name the sub-bank within that bank. The remaining seven low bits pick one of 128 byte entries inside that sub-bank. The read result is registered. It appears on the output at the clock edge that samples the request. Whenever no read is requested, the output returns to zero.

Top module: `banked_mem`

## Requirements
- R1: While rst_n is low, and at the first edge after it, the registered output `rd_data` is 8'h00.
- R2: A write (`wr_en`=1) that is not dropped by R6 stores `wr_data` at `wr_addr`. A later read of that address returns it.
- R3: With `rd_en`=1 at a rising edge, `rd_data` holds the entry at `rd_addr` from that edge onward. The value read is the one stored before any write in the same cycle.
- R4: With `rd_en`=0 at a rising edge, `rd_data` is 8'h00 after that edge.
- R5: Address bits [10:7] form the sub-bank select: bits [10:9] give the bank and bits [8:7] give the sub-bank within it, so select 4'b0110 is bank 1, sub-bank 2. Bits [6:0] give the entry. All 2048 addresses hold distinct storage.
- R6: If `rd_en` and `wr_en` are both 1 and bits [10:7] of the two addresses are equal, only the read is performed, and memory keeps its earlier contents at `wr_addr`.
- R7: If `rd_en` and `wr_en` are both 1 and bits [10:7] differ, the read and the write both complete in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the read output register |
| rd_en | input | 1 | Read request |
| rd_addr | input | 11 | Read address: sub-bank select [10:7], entry [6:0] |
| wr_en | input | 1 | Write request |
| wr_addr | input | 11 | Write address: sub-bank select [10:7], entry [6:0] |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Registered read result, zero when no read |

## Verification
A bad sub-bank decode shows up as aliasing. One address's byte comes back when another address is read, on the first read of any overwritten location. A collision check that is wrong in either direction shows at once. A dropped write that still lands, or a legal write that is lost, changes the byte returned by the next read of that address, and the bench reads every affected address back. A stale or unzeroed output register is caught one cycle after the request, because every cycle's `rd_data` is compared with a model of all 2048 entries.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

  // default geometry of the banked memory
  localparam int BM_DATA_W  = 8;
  localparam int BM_ADDR_W  = 11;
  localparam int BM_BANK_W  = 2;   // bank field width
  localparam int BM_SUBS_W  = 2;   // sub-bank-in-bank field width

  // what happened to the request pair in one cycle
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_DUAL    = 3'd3,
    OP_COLLIDE = 3'd4
  } bm_op_e;

endpackage

// File: rtl/bmem_decode.sv
module bmem_decode
  import bmem_pkg::*;
#(
  parameter int ADDR_W = BM_ADDR_W,
  parameter int BANK_W = BM_BANK_W,
  parameter int SUBS_W = BM_SUBS_W,
  localparam int SEL_W = BANK_W + SUBS_W,
  localparam int N_SUB = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [N_SUB-1:0]  rd_sel_oh,
  output logic [N_SUB-1:0]  wr_sel_oh,
  output logic              wr_commit,
  output logic              wr_drop,
  output bm_op_e            op
);

  // bank number: top BANK_W address bits
  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BANK_W];
  endfunction

  // sub-bank inside the bank: next SUBS_W bits
  function automatic logic [SUBS_W-1:0] sub_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1-BANK_W -: SUBS_W];
  endfunction

  // flat sub-bank index, bank-major
  function automatic logic [SEL_W-1:0] sel_of(input logic [ADDR_W-1:0] a);
    return {bank_of(a), sub_of(a)};
  endfunction

  function automatic logic [N_SUB-1:0] onehot(input logic [SEL_W-1:0] s);
    logic [N_SUB-1:0] v;
    v    = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  logic [SEL_W-1:0] rd_sel;
  logic [SEL_W-1:0] wr_sel;
  logic             same_sub;

  assign rd_sel    = sel_of(rd_addr);
  assign wr_sel    = sel_of(wr_addr);
  assign same_sub  = (rd_sel == wr_sel);

  assign wr_drop   = rd_en && wr_en && same_sub;
  assign wr_commit = wr_en && !wr_drop;

  assign rd_sel_oh = rd_en     ? onehot(rd_sel) : '0;
  assign wr_sel_oh = wr_commit ? onehot(wr_sel) : '0;

  always_comb begin
    if (wr_drop)               op = OP_COLLIDE;
    else if (rd_en && wr_en)   op = OP_DUAL;
    else if (rd_en)            op = OP_READ;
    else if (wr_en)            op = OP_WRITE;
    else                       op = OP_IDLE;
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel_oh) && $onehot0(wr_sel_oh));

  // R6
  collide_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_COLLIDE) |-> (wr_sel_oh == '0 && rd_sel_oh != '0));

endmodule

// File: rtl/bmem_subbank.sv
module bmem_subbank
  import bmem_pkg::*;
#(
  parameter int DATA_W = BM_DATA_W,
  parameter int ROW_W  = BM_ADDR_W - BM_BANK_W - BM_SUBS_W,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  rrow,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[wrow] <= wdata;
  end

  assign rdata = cells[rrow];

  // R2
  store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(wrow)] == $past(wdata)));

endmodule

// File: rtl/bmem_rdmux.sv
module bmem_rdmux
  import bmem_pkg::*;
#(
  parameter int DATA_W = BM_DATA_W,
  parameter int N_SUB  = 1 << (BM_BANK_W + BM_SUBS_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [N_SUB-1:0]             rd_sel_oh,
  input  logic [N_SUB-1:0][DATA_W-1:0] sub_rdata,
  output logic [DATA_W-1:0]            rd_q
);

  logic [DATA_W-1:0] picked;

  // and-or select driven by the one-hot bank choice
  always_comb begin
    picked = '0;
    for (int i = 0; i < N_SUB; i++) begin
      if (rd_sel_oh[i]) picked = picked | sub_rdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= picked;
    else            rd_q <= '0;
  end

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_q == '0));

  // R3
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_q == $past(picked)));

endmodule

// File: rtl/banked_mem.sv
module banked_mem
  import bmem_pkg::*;
#(
  parameter int DATA_W = BM_DATA_W,
  parameter int ADDR_W = BM_ADDR_W,
  parameter int BANK_W = BM_BANK_W,
  parameter int SUBS_W = BM_SUBS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SEL_W = BANK_W + SUBS_W;
  localparam int N_SUB = 1 << SEL_W;
  localparam int ROW_W = ADDR_W - SEL_W;

  logic [N_SUB-1:0]             rd_sel_oh;
  logic [N_SUB-1:0]             wr_sel_oh;
  logic                         wr_commit;
  logic                         wr_drop;
  bm_op_e                       op;
  logic [N_SUB-1:0][DATA_W-1:0] sub_rdata;
  logic [ROW_W-1:0]             rd_row;
  logic [ROW_W-1:0]             wr_row;

  assign rd_row = rd_addr[ROW_W-1:0];
  assign wr_row = wr_addr[ROW_W-1:0];

  bmem_decode #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .SUBS_W (SUBS_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_sel_oh (rd_sel_oh),
    .wr_sel_oh (wr_sel_oh),
    .wr_commit (wr_commit),
    .wr_drop   (wr_drop),
    .op        (op)
  );

  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    bmem_subbank #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W)
    ) u_sb (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_sel_oh[s]),
      .wrow  (wr_row),
      .wdata (wr_data),
      .rrow  (rd_row),
      .rdata (sub_rdata[s])
    );
  end

  bmem_rdmux #(
    .DATA_W (DATA_W),
    .N_SUB  (N_SUB)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_sel_oh (rd_sel_oh),
    .sub_rdata (sub_rdata),
    .rd_q      (rd_data)
  );

  // R6
  drop_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_addr[ADDR_W-1 -: SEL_W] == wr_addr[ADDR_W-1 -: SEL_W])
      |-> (wr_sel_oh == '0 && wr_drop));

  // R7
  dual_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_addr[ADDR_W-1 -: SEL_W] != wr_addr[ADDR_W-1 -: SEL_W])
      |-> ($countones(wr_sel_oh) == 1 && $countones(rd_sel_oh) == 1 && op == OP_DUAL));

  // R2
  write_one_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |-> ($countones(wr_sel_oh) == 1 && wr_commit));

endmodule

// File: tb/banked_mem_test.sv
module banked_mem_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [10:0] rd_addr = '0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;

  logic [7:0]  model [DEPTH];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_mem uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 13 + 7) ^ (a >> 4));
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 29 + 101) ^ 8'h5A);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // one request cycle; the model applies the collision rule itself
  task automatic cyc(input logic r, input logic [10:0] ra,
                     input logic w, input logic [10:0] wa,
                     input logic [7:0] d, input string tag);
    logic [7:0] exp;
    exp = r ? model[ra] : 8'h00;
    if (w && !(r && ra[10:7] == wa[10:7])) model[wa] = d;
    @(negedge clk);
    rd_en = r; rd_addr = ra; wr_en = w; wr_addr = wa; wr_data = d;
    @(posedge clk);
    #1;
    check(tag, rd_data, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", rd_data, 8'h00);

    // R2 / R4: fill every address, no reads, output stays zero
    for (int a = 0; a < DEPTH; a++) cyc(1'b0, '0, 1'b1, 11'(a), pat_a(a), "R4 write-only fill");

    // R3 / R5: read every address back, nothing aliased
    for (int a = 0; a < DEPTH; a++) cyc(1'b1, 11'(a), 1'b0, '0, 8'h00, "R5 readback after fill");

    // R7: read every address while writing a different sub-bank (bit 7 flipped)
    for (int a = 0; a < DEPTH; a++)
      cyc(1'b1, 11'(a), 1'b1, 11'(a) ^ 11'h080, pat_b(a), "R7 dual read with write");

    // R6: collisions in every sub-bank, distinct entry and same entry
    for (int s = 0; s < 16; s++) begin
      cyc(1'b1, {4'(s), 7'd5}, 1'b1, {4'(s), 7'd90}, 8'hC3, "R6 collide read");
      cyc(1'b1, {4'(s), 7'd90}, 1'b0, '0, 8'h00, "R6 dropped write absent");
      cyc(1'b1, {4'(s), 7'd33}, 1'b1, {4'(s), 7'd33}, 8'h3C, "R6 same-entry collide");
      cyc(1'b1, {4'(s), 7'd33}, 1'b0, '0, 8'h00, "R6 same-entry unchanged");
    end

    // R5: select 4'b0110 is bank 1 sub-bank 2, neighbours untouched
    cyc(1'b0, '0, 1'b1, {2'b01, 2'b10, 7'd9}, 8'hA5, "R5 bank1 sub2 write");
    cyc(1'b1, {2'b01, 2'b10, 7'd9}, 1'b0, '0, 8'h00, "R5 bank1 sub2 read");
    cyc(1'b1, {2'b10, 2'b01, 7'd9}, 1'b0, '0, 8'h00, "R5 swapped fields untouched");

    // R4: read then idle returns zero
    cyc(1'b1, 11'd77, 1'b0, '0, 8'h00, "R3 single read");
    cyc(1'b0, 11'd77, 1'b0, '0, 8'h00, "R4 idle zero");

    // R2 / R3: final sweep confirms every location after all traffic
    for (int a = 0; a < DEPTH; a++) cyc(1'b1, 11'(a), 1'b0, '0, 8'h00, "R2 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule